// File: doc/BRIEF.md
# Conversion Sequencer with Start/Busy Status

This block decides when an attached sampling converter runs. It supports two modes, chosen by one bit of an 8-bit settings byte. In free-running mode every finished result is captured and the next conversion is launched at once. In one-shot mode the converter stays powered down until software sets the start/busy bit. That launches exactly one conversion, after which the block powers the converter down again.

The block holds the settings byte and the 16-bit result register. It assembles the readable settings byte, whose top bit is a status flag with mode-dependent meaning. It owns the power-down decision. A soft-reset strobe aborts any conversion, clears the result and restores the default byte 8Ch. If software switches from free-running to one-shot mode, the conversion already in flight is allowed to finish before power-down.

Top module: `conv_sequencer`

## Requirements
- R1: After either reset, `result_q` is 0 and `cfg_rdata` reads 8Ch (free-running mode). On the first clock edge after `rst_n` is released, `cnv_start` pulses high for one cycle and `pwr_down` drops to 0.
- R2: In free-running mode, a `cnv_done` strobe puts `cnv_result` on `result_q` one cycle later. In that same cycle `cnv_start` pulses to begin the next conversion.
- R3: While bit 4 of the stored byte is 0, `cfg_rdata[7]` reads 1. In that mode, bit 7 of a written byte launches no conversion.
- R4: In one-shot mode while powered down, a write with bit 7 = 1 and bit 4 = 1 gives `cnv_start` = 1, `pwr_down` = 0 and `cfg_rdata[7]` = 1 in the next cycle. A write with bit 7 = 0 leaves the block powered down.
- R5: When a one-shot conversion completes, the next cycle shows the result on `result_q`, `pwr_down` = 1 and `cfg_rdata[7]` = 0.
- R6: A write with bit 7 = 1 during a one-shot conversion causes no extra `cnv_start` pulse.
- R7: Writing bit 4 = 1 during free-running mode launches no new conversion and keeps `cfg_rdata[7]` = 1 until the running conversion reports done. After that done strobe the result is stored, `pwr_down` = 1 and `cfg_rdata[7]` = 0.
- R8: A `soft_rst` strobe has priority over a `cnv_done` strobe in the same cycle. In the next cycle the block shows `result_q` = 0, `cfg_rdata` = 8Ch, `pwr_down` = 1 and no `cnv_start`. One cycle later free-running conversion restarts.
- R9: Bit 4 selects the mode and bits 3:0 are stored and read back unchanged. Bits 6:5 always read 0, and bit 7 of `cfg_rdata` is the status flag.
- R10: A `cnv_done` strobe while powered down leaves `result_q` unchanged. `result_q` only changes on an accepted done strobe or a reset.
- R11: A write with bit 4 = 0 while powered down starts free-running conversion: `cnv_start` = 1 and `pwr_down` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous full reset strobe |
| cfg_wr | input | 1 | Settings byte write strobe |
| cfg_wdata | input | 8 | Settings byte written |
| cnv_done | input | 1 | Converter finished strobe |
| cnv_result | input | RES_W | Converter result, valid with `cnv_done` |
| cnv_start | output | 1 | One-cycle pulse launching a conversion |
| pwr_down | output | 1 | Converter powered down |
| result_q | output | RES_W | Last accepted conversion result |
| cfg_rdata | output | 8 | Readable settings byte with status in bit 7 |

## Verification
A wrong sequencer state appears at the ports within one clock. A stuck running state keeps `pwr_down` low and `cfg_rdata[7]` high after a one-shot completion. A missed restart shows as an absent `cnv_start` in the cycle after a free-running done strobe. Mode-switch errors show as a restart pulse or an early power-down while the conversion in flight is still draining. Result-register faults show one cycle after a done strobe, either as a wrong value or as a change while powered down.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int CFG_W       = 8;
  localparam int STB_BIT     = 7;
  localparam int MODE_BIT    = 4;
  localparam logic [CFG_W-1:0] CFG_KEEP  = 8'h1F;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h8C;

  typedef enum logic [1:0] {
    SEQ_POWERDOWN  = 2'd0,
    SEQ_CONVERTING = 2'd1,
    SEQ_CONT_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/conv_cfg_reg.sv
module conv_cfg_reg
  import conv_seq_pkg::*;
#(
  parameter logic [CFG_W-1:0] KEEP_MASK = CFG_KEEP,
  parameter logic [CFG_W-1:0] RESET_VAL = CFG_RESET
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q
);
  logic unused_bits;
  assign unused_bits = ^(wdata & ~KEEP_MASK);

  for (genvar i = 0; i < CFG_W; i++) begin : g_bit
    if (KEEP_MASK[i]) begin : g_keep
      logic bit_d, bit_q;
      always_comb begin
        bit_d = bit_q;
        if (soft_rst)   bit_d = RESET_VAL[i];
        else if (wr_en) bit_d = wdata[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= RESET_VAL[i];
        else        bit_q <= bit_d;
      end
      assign cfg_q[i] = bit_q;
    end else begin : g_zero
      assign cfg_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic cfg_wr,
  input  logic wr_start,
  input  logic wr_single,
  input  logic mode_single_q,
  input  logic cnv_done,
  output logic cnv_start,
  output logic pwr_down,
  output logic busy
);
  seq_state_e state_q, state_d;
  logic start_q, start_d;
  logic mode_eff;

  assign mode_eff = cfg_wr ? wr_single : mode_single_q;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    if (soft_rst) begin
      state_d = SEQ_POWERDOWN;
    end else begin
      case (state_q)
        SEQ_POWERDOWN: begin
          if (!mode_eff) begin
            state_d = SEQ_CONT_RUN;
            start_d = 1'b1;
          end else if (cfg_wr && wr_start) begin
            state_d = SEQ_CONVERTING;
            start_d = 1'b1;
          end
        end
        SEQ_CONVERTING: begin
          if (cnv_done) begin
            if (mode_eff) begin
              state_d = SEQ_POWERDOWN;
            end else begin
              state_d = SEQ_CONT_RUN;
              start_d = 1'b1;
            end
          end else if (!mode_eff) begin
            state_d = SEQ_CONT_RUN;
          end
        end
        SEQ_CONT_RUN: begin
          if (cnv_done) begin
            if (mode_eff) state_d = SEQ_POWERDOWN;
            else          start_d = 1'b1;
          end
        end
        default: state_d = SEQ_POWERDOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_POWERDOWN;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  assign cnv_start = start_q;
  assign pwr_down  = (state_q == SEQ_POWERDOWN);
  assign busy      = !pwr_down;

  AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CONT_RUN && cnv_done && !mode_eff && !soft_rst) |=> cnv_start); // R2
  AST_SINGLE_DONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CONVERTING && cnv_done && mode_eff && !soft_rst) |=> pwr_down); // R5
  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CONVERTING && !cnv_done) |=> !cnv_start); // R6
  AST_DRAIN_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CONT_RUN && !cnv_done) |=> !cnv_start); // R7
  AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> !pwr_down); // R4
endmodule

// File: rtl/conv_result_reg.sv
module conv_result_reg #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             load_en,
  input  logic [RES_W-1:0] load_val,
  output logic [RES_W-1:0] result_q
);
  logic [RES_W-1:0] result_d;

  always_comb begin
    result_d = result_q;
    if (soft_rst)     result_d = '0;
    else if (load_en) result_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else        result_q <= result_d;
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cnv_done,
  input  logic [RES_W-1:0] cnv_result,
  output logic             cnv_start,
  output logic             pwr_down,
  output logic [RES_W-1:0] result_q,
  output logic [CFG_W-1:0] cfg_rdata
);
  logic [CFG_W-1:0] cfg_q;
  logic             busy;
  logic             status;
  logic             load_en;

  conv_cfg_reg #(.KEEP_MASK(CFG_KEEP), .RESET_VAL(CFG_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(cfg_wr), .wdata(cfg_wdata), .cfg_q(cfg_q)
  );

  conv_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfg_wr(cfg_wr), .wr_start(cfg_wdata[STB_BIT]), .wr_single(cfg_wdata[MODE_BIT]),
    .mode_single_q(cfg_q[MODE_BIT]), .cnv_done(cnv_done),
    .cnv_start(cnv_start), .pwr_down(pwr_down), .busy(busy)
  );

  assign load_en = cnv_done && busy;

  conv_result_reg #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .load_en(load_en), .load_val(cnv_result), .result_q(result_q)
  );

  assign status = !cfg_q[MODE_BIT] || busy;

  always_comb begin
    cfg_rdata          = cfg_q;
    cfg_rdata[STB_BIT] = status;
  end

  AST_CONT_STATUS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_wdata[MODE_BIT] && !soft_rst) |=> cfg_rdata[STB_BIT]); // R3
  AST_SOFT_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (pwr_down && result_q == '0 && !cnv_start)); // R8
  AST_IDLE_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && !soft_rst) |=> $stable(result_q)); // R10
  AST_ONESHOT_DONE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_done && !pwr_down && !soft_rst) |=> (result_q == $past(cnv_result))); // R2
endmodule

// File: tb/conv_sequencer_bench.sv
`timescale 1ns/1ps
module conv_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst;
  logic        cfg_wr;
  logic [7:0]  cfg_wdata;
  logic        cnv_done;
  logic [15:0] cnv_result;
  logic        cnv_start;
  logic        pwr_down;
  logic [15:0] result_q;
  logic [7:0]  cfg_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  conv_sequencer u_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cnv_done(cnv_done), .cnv_result(cnv_result),
    .cnv_start(cnv_start), .pwr_down(pwr_down), .result_q(result_q),
    .cfg_rdata(cfg_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic write_cfg(input logic [7:0] b);
    cfg_wr = 1'b1;
    cfg_wdata = b;
    step();
    cfg_wr = 1'b0;
    cfg_wdata = 8'h00;
  endtask

  // driver: push the value result_q must hold after this done strobe
  task automatic done(input logic [15:0] val, input logic [15:0] expect_val);
    exp_q.push_back(expect_val);
    cnv_done = 1'b1;
    cnv_result = val;
    step();
    cnv_done = 1'b0;
    cnv_result = 16'h0;
  endtask

  task automatic outs(input string tag, input bit st, input bit pd, input logic [7:0] cr);
    chk(cnv_start === st, {tag, " cnv_start"}, 32'(cnv_start), 32'(st));
    chk(pwr_down === pd, {tag, " pwr_down"}, 32'(pwr_down), 32'(pd));
    chk(cfg_rdata === cr, {tag, " cfg_rdata"}, 32'(cfg_rdata), 32'(cr));
  endtask

  // monitor: compare result one cycle after every done strobe
  initial begin
    forever begin
      @(posedge clk);
      if (cnv_done === 1'b1) begin
        #3;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 scoreboard underflow", 32'(result_q), 32'h0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(result_q === e, "R2/R5/R10 result_q", 32'(result_q), 32'(e));
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; cfg_wr = 1'b0; cfg_wdata = 8'h00;
    cnv_done = 1'b0; cnv_result = 16'h0;
    repeat (3) @(posedge clk);
    #2;
    chk(result_q === 16'h0, "R1 reset result", 32'(result_q), 32'h0);
    outs("R1 in reset", 1'b0, 1'b1, 8'h8C);
    rst_n = 1'b1;
    step();
    outs("R1 first start", 1'b1, 1'b0, 8'h8C);
    step();
    outs("R2 start single cycle", 1'b0, 1'b0, 8'h8C);

    done(16'h1234, 16'h1234);
    outs("R2 restart a", 1'b1, 1'b0, 8'h8C);
    done(16'h8000, 16'h8000);
    outs("R2 restart b", 1'b1, 1'b0, 8'h8C);

    write_cfg(8'h0C);
    outs("R3 status high", 1'b0, 1'b0, 8'h8C);
    write_cfg(8'h8D);
    outs("R3 start bit ignored", 1'b0, 1'b0, 8'h8D);
    write_cfg(8'h6B);
    outs("R9 reserved read zero", 1'b0, 1'b0, 8'h8B);

    write_cfg(8'h1C);
    outs("R7 drain busy", 1'b0, 1'b0, 8'h9C);
    step();
    outs("R7 drain hold", 1'b0, 1'b0, 8'h9C);
    done(16'h0042, 16'h0042);
    outs("R7 drained off", 1'b0, 1'b1, 8'h1C);

    done(16'h7777, 16'h0042);
    outs("R10 idle done ignored", 1'b0, 1'b1, 8'h1C);

    write_cfg(8'h1C);
    outs("R4 zero write no start", 1'b0, 1'b1, 8'h1C);
    write_cfg(8'h9C);
    outs("R4 one-shot start", 1'b1, 1'b0, 8'h9C);
    step();
    write_cfg(8'h9C);
    outs("R6 start while busy", 1'b0, 1'b0, 8'h9C);
    step();
    done(16'hFFFF, 16'hFFFF);
    outs("R5 one-shot complete", 1'b0, 1'b1, 8'h1C);

    write_cfg(8'h0E);
    outs("R11 enter free-running", 1'b1, 1'b0, 8'h8E);
    done(16'h0001, 16'h0001);
    outs("R2 restart c", 1'b1, 1'b0, 8'h8E);

    write_cfg(8'h1F);
    soft_rst = 1'b1;
    done(16'h5555, 16'h0000);
    soft_rst = 1'b0;
    outs("R8 soft reset", 1'b0, 1'b1, 8'h8C);
    step();
    outs("R8 restart after reset", 1'b1, 1'b0, 8'h8C);
    done(16'h0A0A, 16'h0A0A);
    outs("R2 restart d", 1'b1, 1'b0, 8'h8C);

    repeat (3) step();
    chk(exp_q.size() == 0, "R2 scoreboard drained", 32'(exp_q.size()), 32'h0);
    summary();
  end
endmodule